// File: doc/BRIEF.md
# Machine Status Register Unit

This block keeps the machine-level status word of a RISC-V style hart. It also derives the supervisor-level status view from that word. Software writes arrive through a machine port or a supervisor port. Each write is legalized before it is stored: a field changes only if the extension set chosen at elaboration implements it, and the previous-privilege field never holds an unsupported level. The summary-dirty bit is recomputed after every update, and the XLEN-encoding fields are pinned to the hart's width.

The pipeline reports trap entry and trap return as single-cycle events. The unit saves the interrupt-enable and privilege context on entry and restores it on return. Any update that alters a translation-affecting field raises a one-cycle TLB flush request. A combinational qualifier tells the interrupt logic whether machine interrupts may be taken at the current privilege. The read ports present the full word, the supervisor subset and, on a 32-bit hart, the upper half.

Top module: `mstat_unit`

## Requirements
- R1: After a synchronous reset the word reads as zero except for three things. The endian bits UBE (bit 6), SBE (bit 36) and MBE (bit 37) are set when BIG_ENDIAN is 1. The width fields UXL (bits 33:32) and SXL (bits 35:34) hold their forced encodings. SD is 0.
- R2: A machine write changes a field only if it is implemented. MIE (3), MPIE (7), MPP (12:11), MPRV (17), TW (21) and TSR (22) are always implemented. SIE (1), SPIE (5) and SPP (8) need S. SUM (18), MXR (19) and TVM (20) need both S and an MMU. FS (14:13) needs S, F or V. VS (10:9) needs V. XS (16:15) needs custom extensions. GVA (38) and MPV (39) need both S and H. All other bits keep their old value.
- R3: A requested MPP value is legalized before it is stored. If U is absent, MPP becomes M (3). Otherwise the code 2, and the code 1 when S is absent, become U (0).
- R4: After every update, SD is 1 exactly when FS, XS or VS equals 2'b11. SD sits at bit 63 for XLEN 64 and at bit 31 for XLEN 32.
- R5: UXL is forced to the XLEN encoding (1 for 32, 2 for 64) when U is present. SXL is forced to the same encoding when S is present. Writes cannot change either field.
- R6: tlb_flush is high for exactly the one cycle after an update that changes MPP, MPRV, MXR or SUM. It stays low after updates that change none of them.
- R7: On trap entry, MPIE takes the old MIE, MPP takes cur_priv and MIE clears. MPV takes trap_virt and GVA takes trap_gva, where those fields are implemented.
- R8: On trap return, MIE takes the old MPIE, MPIE becomes 1, and MPP becomes the lowest supported privilege.
- R9: In a given cycle, trap entry overrides trap return, which overrides a machine write, which overrides a supervisor write.
- R10: The supervisor view shows SIE, SPIE, UBE, SPP, FS, XS, SUM, MXR, UXL, SD, and VS when V is present. Every other bit reads as 0.
- R11: A supervisor write can change only SIE, SPIE, SPP, FS, XS, SUM, MXR, and VS when V is present, each still subject to R2. All other fields, including MIE and MPP, are kept.
- R12: On a 32-bit hart the upper-half view carries SBE at bit 4 and MBE at bit 5, with every other bit 0. On a 64-bit hart it reads as 0.
- R13: m_irq_en is 1 when cur_priv is below M (3), or when cur_priv is M and MIE is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_priv | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| trap_enter | input | 1 | Trap into machine mode this cycle |
| trap_virt | input | 1 | Virtualization flag at the trap |
| trap_gva | input | 1 | Trap value is a guest virtual address |
| trap_return | input | 1 | Return from machine trap this cycle |
| m_wr_en | input | 1 | Machine-level status write |
| m_wr_data | input | XLEN | Machine write value |
| s_wr_en | input | 1 | Supervisor-level status write |
| s_wr_data | input | XLEN | Supervisor write value |
| mstat_rd | output | XLEN | Full status view |
| sstat_rd | output | XLEN | Supervisor status view |
| mstath_rd | output | 32 | Upper-half view (32-bit hart) |
| tlb_flush | output | 1 | One-cycle translation flush request |
| m_irq_en | output | 1 | Machine interrupt qualifier |

## Verification
The bench writes all ones and then all zeros. These two writes catch a write mask that lets unimplemented fields such as VS, XS, MPV or GVA through, and an SD bit that follows the written value instead of the stored fields. It asks for the reserved MPP code and for the S code. A design that skips legalization would store 2, and one that forgets to merge after legalizing would lose the S level. Trap entry is applied together with an all-ones machine write, so a design with the wrong priority stores the write instead of the saved context. Flush checks follow both translation-affecting and neutral writes, so a design that flushes on every write, or on none, is caught. A second 32-bit, big-endian copy shows whether the endian bits and SD land at the positions this width requires.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

  typedef logic [63:0] stat_t;

  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_SPIE = 5;
  localparam int B_UBE  = 6;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_VS   = 9;
  localparam int B_MPP  = 11;
  localparam int B_FS   = 13;
  localparam int B_XS   = 15;
  localparam int B_MPRV = 17;
  localparam int B_SUM  = 18;
  localparam int B_MXR  = 19;
  localparam int B_TVM  = 20;
  localparam int B_TW   = 21;
  localparam int B_TSR  = 22;
  localparam int B_UXL  = 32;
  localparam int B_SXL  = 34;
  localparam int B_SBE  = 36;
  localparam int B_MBE  = 37;
  localparam int B_GVA  = 38;
  localparam int B_MPV  = 39;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  function automatic stat_t bit1(input int pos);
    return stat_t'(1) << pos;
  endfunction

  function automatic stat_t bit2(input int pos);
    return stat_t'(3) << pos;
  endfunction

  function automatic logic [1:0] xl_code(input int xlen);
    return (xlen == 64) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/mstat_legalize.sv
module mstat_legalize
  import mstat_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter bit HAS_S      = 1'b1,
  parameter bit HAS_U      = 1'b1,
  parameter bit HAS_H      = 1'b0,
  parameter bit HAS_F      = 1'b1,
  parameter bit HAS_V      = 1'b0,
  parameter bit HAS_CUSTOM = 1'b0,
  parameter bit HAS_MMU    = 1'b1
) (
  input  stat_t old_q,
  input  stat_t cand,
  output stat_t nxt
);

  localparam int         SD_POS = XLEN - 1;
  localparam logic [1:0] XL     = xl_code(XLEN);
  localparam bit         PAGE   = HAS_S && HAS_MMU;

  localparam stat_t M_BASE = bit1(B_MIE) | bit1(B_MPIE) | bit1(B_MPRV)
                           | bit2(B_MPP) | bit1(B_TW) | bit1(B_TSR);
  localparam stat_t M_SUP  = HAS_S ? (bit1(B_SIE) | bit1(B_SPIE) | bit1(B_SPP)) : '0;
  localparam stat_t M_PAGE = PAGE ? (bit1(B_MXR) | bit1(B_SUM) | bit1(B_TVM)) : '0;
  localparam stat_t M_FS   = (HAS_S || HAS_F || HAS_V) ? bit2(B_FS) : '0;
  localparam stat_t M_VS   = HAS_V ? bit2(B_VS) : '0;
  localparam stat_t M_XS   = HAS_CUSTOM ? bit2(B_XS) : '0;
  localparam stat_t M_HYP  = (HAS_S && HAS_H) ? (bit1(B_GVA) | bit1(B_MPV)) : '0;
  localparam stat_t WMASK  = M_BASE | M_SUP | M_PAGE | M_FS | M_VS | M_XS | M_HYP;

  logic [1:0] req_mpp;
  logic [1:0] legal_mpp;
  stat_t      fixed_cand;
  stat_t      merged;
  logic       dirty;

  always_comb begin
    req_mpp = cand[B_MPP +: 2];
    if (!HAS_U)
      legal_mpp = PRIV_M;
    else if (req_mpp == 2'd2 || (req_mpp == PRIV_S && !HAS_S))
      legal_mpp = PRIV_U;
    else
      legal_mpp = req_mpp;
  end

  always_comb begin
    fixed_cand = cand;
    fixed_cand[B_MPP +: 2] = legal_mpp;
    merged = (old_q & ~WMASK) | (fixed_cand & WMASK);
    dirty = (&merged[B_FS +: 2]) | (&merged[B_XS +: 2]) | (&merged[B_VS +: 2]);
    nxt = merged;
    nxt[SD_POS] = dirty;
    if (HAS_U) nxt[B_UXL +: 2] = XL;
    if (HAS_S) nxt[B_SXL +: 2] = XL;
  end

endmodule

// File: rtl/mstat_event.sv
module mstat_event
  import mstat_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_V = 1'b0
) (
  input  stat_t            old_q,
  input  logic [1:0]       cur_priv,
  input  logic             trap_enter,
  input  logic             trap_virt,
  input  logic             trap_gva,
  input  logic             trap_return,
  input  logic             m_wr_en,
  input  logic [XLEN-1:0]  m_wr_data,
  input  logic             s_wr_en,
  input  logic [XLEN-1:0]  s_wr_data,
  output logic             update,
  output stat_t            cand
);

  localparam stat_t SW_MASK = bit1(B_SIE) | bit1(B_SPIE) | bit1(B_SPP)
                            | bit2(B_FS) | bit2(B_XS) | bit1(B_SUM) | bit1(B_MXR)
                            | (HAS_V ? bit2(B_VS) : '0);
  localparam logic [1:0] LOW_PRIV = HAS_U ? PRIV_U : PRIV_M;

  stat_t wide_m;
  stat_t wide_s;

  generate
    if (XLEN == 64) begin : g_w64
      assign wide_m = stat_t'(m_wr_data);
      assign wide_s = stat_t'(s_wr_data);
    end else begin : g_w32
      assign wide_m = {old_q[63:32], m_wr_data};
      assign wide_s = {old_q[63:32], s_wr_data};
    end
  endgenerate

  always_comb begin
    cand   = old_q;
    update = trap_enter | trap_return | m_wr_en | s_wr_en;
    if (trap_enter) begin
      cand[B_MPIE]      = old_q[B_MIE];
      cand[B_MPP +: 2]  = cur_priv;
      cand[B_MIE]       = 1'b0;
      cand[B_MPV]       = trap_virt;
      cand[B_GVA]       = trap_gva;
    end else if (trap_return) begin
      cand[B_MIE]       = old_q[B_MPIE];
      cand[B_MPIE]      = 1'b1;
      cand[B_MPP +: 2]  = LOW_PRIV;
    end else if (m_wr_en) begin
      cand = wide_m;
    end else if (s_wr_en) begin
      cand = (old_q & ~SW_MASK) | (wide_s & SW_MASK);
    end
  end

endmodule

// File: rtl/mstat_views.sv
module mstat_views
  import mstat_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter bit HAS_V = 1'b0
) (
  input  stat_t            q,
  output logic [XLEN-1:0]  m_view,
  output logic [XLEN-1:0]  s_view,
  output logic [31:0]      h_view
);

  localparam stat_t SR_MASK = bit1(B_SIE) | bit1(B_SPIE) | bit1(B_UBE) | bit1(B_SPP)
                            | bit2(B_FS) | bit2(B_XS) | bit1(B_SUM) | bit1(B_MXR)
                            | bit2(B_UXL) | bit1(XLEN - 1)
                            | (HAS_V ? bit2(B_VS) : '0);
  localparam logic [31:0] H_MASK = (32'd1 << (B_SBE - 32)) | (32'd1 << (B_MBE - 32));

  stat_t s_full;
  assign s_full = q & SR_MASK;

  generate
    if (XLEN == 64) begin : g_w64
      assign m_view = q;
      assign s_view = s_full;
      assign h_view = '0;
    end else begin : g_w32
      assign m_view = q[31:0];
      assign s_view = s_full[31:0];
      assign h_view = q[63:32] & H_MASK;
    end
  endgenerate

endmodule

// File: rtl/mstat_unit.sv
module mstat_unit
  import mstat_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter bit HAS_S      = 1'b1,
  parameter bit HAS_U      = 1'b1,
  parameter bit HAS_H      = 1'b0,
  parameter bit HAS_F      = 1'b1,
  parameter bit HAS_V      = 1'b0,
  parameter bit HAS_CUSTOM = 1'b0,
  parameter bit HAS_MMU    = 1'b1,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cur_priv,
  input  logic             trap_enter,
  input  logic             trap_virt,
  input  logic             trap_gva,
  input  logic             trap_return,
  input  logic             m_wr_en,
  input  logic [XLEN-1:0]  m_wr_data,
  input  logic             s_wr_en,
  input  logic [XLEN-1:0]  s_wr_data,
  output logic [XLEN-1:0]  mstat_rd,
  output logic [XLEN-1:0]  sstat_rd,
  output logic [31:0]      mstath_rd,
  output logic             tlb_flush,
  output logic             m_irq_en
);

  localparam stat_t INIT  = BIG_ENDIAN ? (bit1(B_UBE) | bit1(B_SBE) | bit1(B_MBE)) : '0;
  localparam stat_t FMASK = bit2(B_MPP) | bit1(B_MPRV) | bit1(B_MXR) | bit1(B_SUM);

  stat_t q;
  stat_t cand;
  stat_t nxt;
  stat_t rst_val;
  logic  update;
  logic  past_ok;

  mstat_event #(.XLEN(XLEN), .HAS_U(HAS_U), .HAS_V(HAS_V)) u_event (
    .old_q(q), .cur_priv(cur_priv),
    .trap_enter(trap_enter), .trap_virt(trap_virt), .trap_gva(trap_gva),
    .trap_return(trap_return),
    .m_wr_en(m_wr_en), .m_wr_data(m_wr_data),
    .s_wr_en(s_wr_en), .s_wr_data(s_wr_data),
    .update(update), .cand(cand)
  );

  mstat_legalize #(
    .XLEN(XLEN), .HAS_S(HAS_S), .HAS_U(HAS_U), .HAS_H(HAS_H), .HAS_F(HAS_F),
    .HAS_V(HAS_V), .HAS_CUSTOM(HAS_CUSTOM), .HAS_MMU(HAS_MMU)
  ) u_legal (
    .old_q(q), .cand(cand), .nxt(nxt)
  );

  // reset value passes through the same legalization as a write
  mstat_legalize #(
    .XLEN(XLEN), .HAS_S(HAS_S), .HAS_U(HAS_U), .HAS_H(HAS_H), .HAS_F(HAS_F),
    .HAS_V(HAS_V), .HAS_CUSTOM(HAS_CUSTOM), .HAS_MMU(HAS_MMU)
  ) u_legal_rst (
    .old_q(INIT), .cand(INIT), .nxt(rst_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q         <= rst_val;
      tlb_flush <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      past_ok   <= 1'b1;
      tlb_flush <= update && (|((nxt ^ q) & FMASK));
      if (update) q <= nxt;
    end
  end

  mstat_views #(.XLEN(XLEN), .HAS_V(HAS_V)) u_views (
    .q(q), .m_view(mstat_rd), .s_view(sstat_rd), .h_view(mstath_rd)
  );

  assign m_irq_en = (cur_priv != PRIV_M) || q[B_MIE];

  // R3: stored MPP is never the reserved code
  p_mpp_legal_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> q[B_MPP +: 2] != 2'd2);

  // R4: SD agrees with the state fields
  p_sd_track_r4: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> q[XLEN-1] == ((&q[B_FS +: 2]) | (&q[B_XS +: 2]) | (&q[B_VS +: 2])));

  // R5: width encoding stays pinned
  p_uxl_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && HAS_U) |-> q[B_UXL +: 2] == xl_code(XLEN));

  // R6: any change of a translation field comes with a flush
  p_flush_on_change_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(past_ok) && ((q & FMASK) != $past(q & FMASK))) |-> tlb_flush);

  // R7: trap entry disables machine interrupts
  p_trap_mie_r7: assert property (@(posedge clk) disable iff (rst)
    trap_enter |=> !q[B_MIE]);

  // R8: trap return sets MPIE
  p_ret_mpie_r8: assert property (@(posedge clk) disable iff (rst)
    (trap_return && !trap_enter) |=> q[B_MPIE]);

endmodule

// File: tb/mstat_unit_test.sv
`timescale 1ns/1ps
module mstat_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cur_priv = 2'd3;
  logic        trap_enter = 1'b0, trap_virt = 1'b0, trap_gva = 1'b0, trap_return = 1'b0;
  logic        m_wr_en = 1'b0, s_wr_en = 1'b0;
  logic [63:0] m_wr_data = '0, s_wr_data = '0;
  logic [63:0] mstat_rd, sstat_rd;
  logic [31:0] mstath_rd;
  logic        tlb_flush, m_irq_en;
  logic [31:0] w_mstat, w_sstat, w_mstath;
  logic        w_flush, w_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mstat_unit uut (
    .clk(clk), .rst(rst), .cur_priv(cur_priv),
    .trap_enter(trap_enter), .trap_virt(trap_virt), .trap_gva(trap_gva),
    .trap_return(trap_return),
    .m_wr_en(m_wr_en), .m_wr_data(m_wr_data),
    .s_wr_en(s_wr_en), .s_wr_data(s_wr_data),
    .mstat_rd(mstat_rd), .sstat_rd(sstat_rd), .mstath_rd(mstath_rd),
    .tlb_flush(tlb_flush), .m_irq_en(m_irq_en)
  );

  mstat_unit #(.XLEN(32), .BIG_ENDIAN(1'b1)) uut_w32 (
    .clk(clk), .rst(rst), .cur_priv(cur_priv),
    .trap_enter(trap_enter), .trap_virt(trap_virt), .trap_gva(trap_gva),
    .trap_return(trap_return),
    .m_wr_en(m_wr_en), .m_wr_data(m_wr_data[31:0]),
    .s_wr_en(s_wr_en), .s_wr_data(s_wr_data[31:0]),
    .mstat_rd(w_mstat), .sstat_rd(w_sstat), .mstath_rd(w_mstath),
    .tlb_flush(w_flush), .m_irq_en(w_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic mwrite(input logic [63:0] d);
    @(negedge clk); m_wr_en = 1'b1; m_wr_data = d;
    @(negedge clk); m_wr_en = 1'b0;
  endtask

  task automatic swrite(input logic [63:0] d);
    @(negedge clk); s_wr_en = 1'b1; s_wr_data = d;
    @(negedge clk); s_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset word", mstat_rd, 64'h0000_000A_0000_0000);
    chk("R10 reset s-view", sstat_rd, 64'h0000_0002_0000_0000);
    chk("R12 upper view 64-bit", {32'd0, mstath_rd}, 64'd0);
    chk("R1 flush idle", {63'd0, tlb_flush}, 64'd0);
    chk("R1 reset word w32 big-endian", {32'd0, w_mstat}, 64'h40);
    chk("R12 upper view w32", {32'd0, w_mstath}, 64'h30);
  endtask

  task automatic t_all_ones();
    mwrite('1);
    chk("R2 R4 R5 all-ones write", mstat_rd, 64'h8000_000A_007E_79AA);
    chk("R6 flush on MPP change", {63'd0, tlb_flush}, 64'd1);
    chk("R4 SD at bit31 w32", {32'd0, w_mstat}, 64'h807E_79EA);
    chk("R12 upper view kept w32", {32'd0, w_mstath}, 64'h30);
    @(negedge clk);
    chk("R6 flush one cycle", {63'd0, tlb_flush}, 64'd0);
  endtask

  task automatic t_zero_and_mask();
    mwrite('0);
    chk("R4 clear write", mstat_rd, 64'h0000_000A_0000_0000);
    chk("R6 flush on clear", {63'd0, tlb_flush}, 64'd1);
    mwrite(64'h0000_00C0_0001_8600);
    chk("R2 VS XS GVA MPV not writable", mstat_rd, 64'h0000_000A_0000_0000);
    chk("R6 no flush without change", {63'd0, tlb_flush}, 64'd0);
  endtask

  task automatic t_mpp_legal();
    mwrite(64'h1000);
    chk("R3 reserved MPP to U", mstat_rd, 64'h0000_000A_0000_0000);
    mwrite(64'h0800);
    chk("R3 MPP S kept", mstat_rd, 64'h0000_000A_0000_0800);
    chk("R6 flush MPP U->S", {63'd0, tlb_flush}, 64'd1);
    mwrite(64'h0020_2000);
    chk("R4 FS partial no SD", mstat_rd, 64'h0000_000A_0020_2000);
    mwrite(64'h2000);
    chk("R2 TW cleared", mstat_rd, 64'h0000_000A_0000_2000);
    chk("R6 no flush TW change", {63'd0, tlb_flush}, 64'd0);
  endtask

  task automatic t_trap();
    mwrite(64'h8);
    @(negedge clk);
    cur_priv = 2'd1; trap_virt = 1'b1; trap_gva = 1'b1; trap_enter = 1'b1;
    m_wr_en = 1'b1; m_wr_data = '1;
    @(negedge clk);
    trap_enter = 1'b0; m_wr_en = 1'b0; trap_virt = 1'b0; trap_gva = 1'b0;
    chk("R7 R9 trap entry over write", mstat_rd, 64'h0000_000A_0000_0880);
    chk("R6 flush on trap MPP", {63'd0, tlb_flush}, 64'd1);
    @(negedge clk); trap_return = 1'b1;
    @(negedge clk); trap_return = 1'b0;
    chk("R8 trap return", mstat_rd, 64'h0000_000A_0000_0088);
    chk("R6 flush on return MPP", {63'd0, tlb_flush}, 64'd1);
  endtask

  task automatic t_super();
    mwrite('1);
    chk("R10 s-view", sstat_rd, 64'h8000_0002_000C_6122);
    swrite('0);
    chk("R11 supervisor write", mstat_rd, 64'h0000_000A_0072_1888);
    chk("R6 flush on SUM MXR", {63'd0, tlb_flush}, 64'd1);
  endtask

  task automatic t_irq();
    cur_priv = 2'd3; #1;
    chk("R13 M with MIE", {63'd0, m_irq_en}, 64'd1);
    mwrite('0);
    cur_priv = 2'd3; #1;
    chk("R13 M without MIE", {63'd0, m_irq_en}, 64'd0);
    cur_priv = 2'd1; #1;
    chk("R13 S without MIE", {63'd0, m_irq_en}, 64'd1);
    cur_priv = 2'd0; #1;
    chk("R13 U without MIE", {63'd0, m_irq_en}, 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_all_ones();
    t_zero_and_mask();
    t_mpp_legal();
    t_trap();
    t_super();
    t_irq();
    finish_run();
  end

endmodule